// File: doc/BRIEF.md
# UART Baud Rate Generator

This block produces the timing enables for a serial port. A 16-bit divisor, kept as two byte-wide latches, counts down the system clock and emits a one-cycle pulse every N clocks. That pulse runs at sixteen times the serial bit rate. A 4-bit sub-counter then turns every sixteenth of those pulses into a second one-cycle pulse at the bit rate itself. A programmed divisor of 0 or 1 is replaced by 32 inside the counter. The latches keep the value software wrote.

Software reaches the latches through a small byte-wide register port with an address, a write enable, write data and combinational read data. A control register holds a divisor-access bit. The two divisor offsets reach the latches only while that bit is 1. While it is 0, those offsets are left to other registers that sit outside this block. Writing either divisor byte restarts the count from the new value, and the sub-counter starts again with it.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset both divisor bytes and the control register read 0, and the 16x pulse repeats every 32 clocks.
- R2: With the access bit set, offset 0 holds the low byte and offset 1 the high byte of one binary divisor N. The 16x pulse `tick16_o` is high for one clock in every N clocks.
- R3: A stored divisor of 0 or 1 gives a 16x period of exactly 32 clocks.
- R4: With the access bit set, reads of offsets 0 and 1 return the stored bytes unchanged, including a stored 0 or 1.
- R5: With the access bit clear, writes to offsets 0 and 1 leave the latches and the pulse period unchanged, and reads of those offsets return 0.
- R6: The control register sits at offset 3. Its bit 7 is the divisor-access bit. Only bit 7 is stored, and the other bits read 0.
- R7: A write to either divisor byte restarts the count. The first 16x pulse comes in the Nth clock, counting the clock whose edge took the write as clock 1.
- R8: `tick_baud_o` rises only together with `tick16_o`. After a divisor write, it comes on the 16th 16x pulse, 16*N clocks after the write, and then on every 16th pulse after that.
- R9: `tick16_o` is never high in two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Write strobe, one write per clock |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tick16_o | output | 1 | One-cycle enable at 16x the bit rate |
| tick_baud_o | output | 1 | One-cycle enable at the bit rate |

## Verification
The bench programs 0 and 1 and checks both the 32-clock period and the readback. A design that put the substitution into the latch itself would read back 32, and one that left it out would pulse every clock or stop altogether. It also writes the divisor offsets with the access bit clear. A decoder that ignored the bit would change the period and corrupt the stored bytes. It measures the first pulse after each write, including 430, 651 and 214, and a random set of small and large divisors. A design that kept the stale count would give a short or long first period. A design that did not clear the sub-counter would give the first bit-rate pulse earlier than 16*N clocks.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned DEF_BYTES    = 2;
  localparam int unsigned DEF_ADDR_W   = 3;
  localparam int unsigned DEF_CTRL_ADR = 3;
  localparam int unsigned DEF_ACC_BIT  = 7;
  localparam int unsigned DEF_FALLBACK = 32;
  localparam int unsigned DEF_SUB_W    = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/uart_rst_sync.sv
module uart_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/uart_div_regs.sv
module uart_div_regs
  import uart_baud_pkg::*;
#(
  parameter int unsigned DATA_W    = BYTE_W,
  parameter int unsigned DIV_BYTES = DEF_BYTES,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned CTRL_ADR  = DEF_CTRL_ADR,
  parameter int unsigned ACC_BIT   = DEF_ACC_BIT,
  localparam int unsigned DIV_W    = DATA_W * DIV_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]  div_next,
  output logic              div_load
);

  logic                 acc_q, acc_d, ctrl_en;
  logic [DIV_W-1:0]     div_q, div_d;
  logic [DIV_BYTES-1:0] byte_hit;
  reg_sel_e             sel;

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(CTRL_ADR)) begin
      sel = SEL_CTRL;
    end else if (acc_q && (addr < ADDR_W'(DIV_BYTES))) begin
      sel = SEL_DIV;
    end
  end

  for (genvar gi = 0; gi < DIV_BYTES; gi++) begin : g_byte
    assign byte_hit[gi] = we && (sel == SEL_DIV) && (addr == ADDR_W'(gi));
    assign div_d[gi*DATA_W +: DATA_W] = byte_hit[gi] ? wdata
                                                     : div_q[gi*DATA_W +: DATA_W];
  end

  assign div_load = |byte_hit;
  assign div_next = div_d;
  assign ctrl_en  = we && (sel == SEL_CTRL);
  assign acc_d    = wdata[ACC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      acc_q <= 1'b0;
    end else begin
      if (div_load) div_q <= div_d;
      if (ctrl_en)  acc_q <= acc_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CTRL: rdata[ACC_BIT] = acc_q;
      SEL_DIV: begin
        for (int i = 0; i < int'(DIV_BYTES); i++) begin
          if (addr == ADDR_W'(i)) rdata = div_q[i*DATA_W +: DATA_W];
        end
      end
      default: rdata = '0;
    endcase
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_q && we && (addr < ADDR_W'(DIV_BYTES))) |=> $stable(div_q)); // R5
  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_q && (addr < ADDR_W'(DIV_BYTES))) |-> (rdata == '0)); // R5
  AST_CTRL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(CTRL_ADR)) |-> ($countones(rdata) <= 1)); // R6

endmodule

// File: rtl/uart_tick_div.sv
module uart_tick_div #(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned FALLBACK = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_div,
  input  logic [DIV_W-1:0] cur_div,
  output logic             tick16
);

  localparam logic [DIV_W-1:0] FALL_V = DIV_W'(FALLBACK);
  localparam logic [DIV_W-1:0] ONE_V  = DIV_W'(1);

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] raw);
    return (raw <= ONE_V) ? FALL_V : raw;
  endfunction

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == ONE_V);

  always_comb begin
    if (load) begin
      cnt_d = eff_div(load_div);
    end else if (at_end) begin
      cnt_d = eff_div(cur_div);
    end else begin
      cnt_d = cnt_q - ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= FALL_V;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick16 = at_end;

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |=> !tick16); // R9
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (cnt_q > ONE_V)) |=> (cnt_q == $past(cnt_q) - ONE_V)); // R2
  AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (load || at_end) |=> (cnt_q >= DIV_W'(2))); // R3
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0); // R3

endmodule

// File: rtl/uart_baud_sub.sv
module uart_baud_sub #(
  parameter int unsigned SUB_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick16,
  output logic tick_baud
);

  logic [SUB_W-1:0] sub_q, sub_d;
  logic             sub_en;

  assign sub_en = clear || tick16;

  always_comb begin
    sub_d = clear ? '0 : sub_q + SUB_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (sub_en) begin
      sub_q <= sub_d;
    end
  end

  assign tick_baud = tick16 && (&sub_q);

  AST_SUB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sub_q == '0)); // R7
  AST_SUB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick16) |=> $stable(sub_q)); // R8

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int unsigned DIV_BYTES = DEF_BYTES,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned CTRL_ADR  = DEF_CTRL_ADR,
  parameter int unsigned ACC_BIT   = DEF_ACC_BIT,
  parameter int unsigned FALLBACK  = DEF_FALLBACK,
  parameter int unsigned SUB_W     = DEF_SUB_W,
  localparam int unsigned DIV_W    = BYTE_W * DIV_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              tick16_o,
  output logic              tick_baud_o
);

  logic             rst_n_int;
  logic [DIV_W-1:0] div_next;
  logic             div_load;
  logic [DIV_W-1:0] div_cur_q;

  uart_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  uart_div_regs #(
    .DATA_W    (BYTE_W),
    .DIV_BYTES (DIV_BYTES),
    .ADDR_W    (ADDR_W),
    .CTRL_ADR  (CTRL_ADR),
    .ACC_BIT   (ACC_BIT)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .addr     (reg_addr),
    .we       (reg_we),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .div_next (div_next),
    .div_load (div_load)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      div_cur_q <= '0;
    end else if (div_load) begin
      div_cur_q <= div_next;
    end
  end

  uart_tick_div #(
    .DIV_W    (DIV_W),
    .FALLBACK (FALLBACK)
  ) i_tick_div (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (div_load),
    .load_div (div_next),
    .cur_div  (div_cur_q),
    .tick16   (tick16_o)
  );

  uart_baud_sub #(
    .SUB_W (SUB_W)
  ) i_baud_sub (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clear     (div_load),
    .tick16    (tick16_o),
    .tick_baud (tick_baud_o)
  );

  AST_BAUD_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n_int)
    tick_baud_o |-> tick16_o); // R8

endmodule

// File: tb/test_uart_baud_gen.sv
module test_uart_baud_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick16_o, tick_baud_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uart_baud_gen i_uart_baud_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .tick16_o    (tick16_o),
    .tick_baud_o (tick_baud_o)
  );

  function automatic int exp_eff(input int d);
    return (d <= 1) ? 32 : d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write at the next edge; returns at the first negedge after it (cycle 1)
  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = 8'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 d = int'(reg_rdata);
  endtask

  // counts from cycle 1 (current negedge) to the first tick16
  task automatic cycles_to_tick(output int n);
    n = 1;
    while (!tick16_o && n < 20000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic period(output int n);
    int k;
    cycles_to_tick(k);
    @(negedge clk);
    cycles_to_tick(n);
  endtask

  task automatic program_div(input int d, input bit chk_baud);
    int n, rv, ticks;
    wr(1, d >> 8);
    wr(0, d & 8'hFF);
    if (chk_baud) begin
      n = 1; ticks = 0;
      while (n < 20000) begin
        if (tick16_o) ticks++;
        if (tick_baud_o) break;
        @(negedge clk); n++;
      end
      check("R8 baud after write", n, 16 * exp_eff(d));
      check("R8 baud on 16th tick", ticks, 16);
    end else begin
      cycles_to_tick(n);
      check("R7 first tick after write", n, exp_eff(d));
    end
    @(negedge clk);
    cycles_to_tick(n);
    check("R2 tick period", n, exp_eff(d));
    rd(0, rv); check("R4 low byte", rv, d & 8'hFF);
    rd(1, rv); check("R4 high byte", rv, d >> 8);
  endtask

  initial begin
    int v, p, d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(0, v); check("R1 low reset", v, 0);
    rd(1, v); check("R1 high reset", v, 0);
    rd(3, v); check("R1 ctrl reset", v, 0);
    period(p); check("R1 reset period", p, 32);

    wr(3, 8'h80);
    rd(3, v); check("R6 access bit", v, 8'h80);
    rd(0, v); check("R1 low after unlock", v, 0);
    wr(3, 8'hFF);
    rd(3, v); check("R6 spare bits", v, 8'h80);

    program_div(430, 1'b0);
    program_div(430, 1'b1);
    program_div(651, 1'b0);
    program_div(214, 1'b1);
    program_div(0, 1'b0);
    program_div(1, 1'b1);
    program_div(2, 1'b1);

    program_div(37, 1'b0);
    wr(3, 8'h00);
    rd(0, v); check("R5 locked read low", v, 0);
    rd(1, v); check("R5 locked read high", v, 0);
    wr(0, 8'h05);
    wr(1, 8'h02);
    period(p); check("R5 period kept", p, 37);
    wr(3, 8'h80);
    rd(0, v); check("R5 low kept", v, 37);
    rd(1, v); check("R5 high kept", v, 0);

    for (int i = 0; i < 10; i++) begin
      d = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 900))
                                      : int'($urandom_range(0, 40));
      program_div(d, (i % 3) == 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule